// File: doc/BRIEF.md
# Acquisition Window Controller

This block sequences one measurement acquisition at a time. Software issues a start command. The block then either opens its acquisition window at once, or first arms and waits for a rising edge on an external synchronisation input. While the window is open, a flag marks the acquisition as active. The window stays open for a programmed number of millisecond ticks. The tick is a single-cycle strobe that the surrounding chip provides.

When the window closes on its own, the block drives a fixed-width end-of-acquisition pulse. It can also drive a fixed-width gate pulse as the window opens, and this pulse comes once per measurement. An abort command returns the block to rest from any phase without the end pulse. The trigger-mode and gate enables are sampled at the moments they matter: the trigger mode when the start command is taken, and the gate enable when the window opens.

Top module: `acq_window_ctrl`

## Requirements
- R1: During and right after reset, `acq_active`, `sync_out` and `gate_out` are all low and the block rests idle.
- R2: With `ext_trig_en` low, a start command taken at a clock edge raises `acq_active` at that same edge. Rising edges on `sync_in` while idle never open a window.
- R3: With `ext_trig_en` high, a start command arms the block, and `acq_active` stays low for as long as no new rising edge of `sync_in` arrives; there is no timeout. Only a low-to-high transition counts, so a level already high at arming does not open the window. `acq_active` rises at the third clock edge that samples `sync_in` high.
- R4: The window covers exactly N `ms_tick` strobes, where N is the unsigned 32-bit `dwell_ms` value latched when the window opens. `acq_active` falls at the edge that samples the N-th strobe, and strobes outside an open window have no effect.
- R5: A `dwell_ms` of 0 is treated as 1, so the window closes on the first tick.
- R6: Every window that closes by expiry drives `sync_out` high for exactly 4 clock cycles, starting at the edge where `acq_active` falls. This holds in both trigger modes.
- R7: If `gate_en` is high when the window opens, `gate_out` goes high for exactly 4 cycles starting at the edge where `acq_active` rises. No further gate pulse occurs during that measurement, and none occurs at all when `gate_en` is low.
- R8: `cmd_abort` has priority over every other input. From armed or running, the block is idle after the next edge with `acq_active` low, and no `sync_out` pulse follows.
- R9: A start command is ignored while the block is armed or running. It neither reopens the window nor resets its tick count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Single-cycle start command |
| cmd_abort | input | 1 | Single-cycle abort command |
| sync_in | input | 1 | Asynchronous external trigger, synchronised inside |
| ms_tick | input | 1 | Millisecond strobe, one cycle wide |
| dwell_ms | input | 32 | Window length in ticks (0 acts as 1) |
| ext_trig_en | input | 1 | Wait for a `sync_in` edge before opening |
| gate_en | input | 1 | Emit a gate pulse when the window opens |
| acq_active | output | 1 | Window open |
| sync_out | output | 1 | End-of-acquisition pulse, 4 cycles |
| gate_out | output | 1 | Start-of-measurement gate pulse, 4 cycles |

## Verification
The hardest state to reach from the ports is an armed block that faces a `sync_in` level already high, or ticks and repeated start commands that arrive while it waits. The stimulus raises `sync_in` before arming and holds it there for many cycles. It then aborts and toggles the input to show that no stale edge survives. Random runs interleave extra start pulses between ticks while the window is open, with tick spacing as tight as every cycle. This includes the case where the gate pulse outlives a one-tick window.

// File: rtl/acqw_pkg.sv
package acqw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } acq_state_e;
endpackage

// File: rtl/acqw_sync_edge.sv
// Synchroniser chain for an asynchronous level, plus a rising-edge strobe.
module acqw_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-1:0], din};
  end

  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/acqw_dwell_timer.sv
// Counts remaining ticks of the window; zero length is clamped to one.
module acqw_dwell_timer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  input  logic         tick,
  output logic         expire
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] remaining;
  logic [W-1:0] clamped;

  assign clamped = (load_val == '0) ? ONE : load_val;
  assign expire  = run & tick & (remaining == ONE);

  always_ff @(posedge clk) begin
    if (rst)                             remaining <= '0;
    else if (load)                       remaining <= clamped;
    else if (run && tick && remaining > ONE) remaining <= remaining - ONE;
  end
endmodule

// File: rtl/acqw_pulse.sv
// Registered fixed-width pulse; a new fire restarts the width.
module acqw_pulse #(
  parameter int WIDTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic pulse
);
  localparam int CW = $clog2(WIDTH + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (fire) begin
      cnt   <= CW'(WIDTH - 1);
      pulse <= 1'b1;
    end else if (cnt != '0) begin
      cnt   <= cnt - CW'(1);
    end else begin
      pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/acq_window_ctrl.sv
module acq_window_ctrl #(
  parameter int DWELL_W     = 32,
  parameter int PULSE_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_start,
  input  logic               cmd_abort,
  input  logic               sync_in,
  input  logic               ms_tick,
  input  logic [DWELL_W-1:0] dwell_ms,
  input  logic               ext_trig_en,
  input  logic               gate_en,
  output logic               acq_active,
  output logic               sync_out,
  output logic               gate_out
);
  import acqw_pkg::*;

  acq_state_e state, nxt;
  logic sync_rise, expire, open_win, end_win;

  acqw_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(sync_in), .rise(sync_rise)
  );

  acqw_dwell_timer #(.W(DWELL_W)) u_timer (
    .clk(clk), .rst(rst), .load(open_win), .load_val(dwell_ms),
    .run(state == ST_RUN), .tick(ms_tick), .expire(expire)
  );

  always_comb begin
    nxt      = state;
    open_win = 1'b0;
    end_win  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (!cmd_abort && cmd_start) begin
          if (ext_trig_en) nxt = ST_ARM;
          else begin
            nxt      = ST_RUN;
            open_win = 1'b1;
          end
        end
      end
      ST_ARM: begin
        if (cmd_abort) nxt = ST_IDLE;
        else if (sync_rise) begin
          nxt      = ST_RUN;
          open_win = 1'b1;
        end
      end
      ST_RUN: begin
        if (cmd_abort) nxt = ST_IDLE;
        else if (expire) begin
          nxt     = ST_DONE;
          end_win = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      acq_active <= 1'b0;
    end else begin
      state      <= nxt;
      acq_active <= (nxt == ST_RUN);
    end
  end

  acqw_pulse #(.WIDTH(PULSE_W)) u_end_pulse (
    .clk(clk), .rst(rst), .fire(end_win), .pulse(sync_out)
  );

  acqw_pulse #(.WIDTH(PULSE_W)) u_gate_pulse (
    .clk(clk), .rst(rst), .fire(open_win & gate_en), .pulse(gate_out)
  );
endmodule

// File: rtl/acqw_checker.sv
module acqw_checker #(
  parameter int PULSE_W = 4
) (
  input logic clk,
  input logic rst,
  input logic cmd_abort,
  input logic ms_tick,
  input logic gate_en,
  input logic acq_active,
  input logic sync_out,
  input logic gate_out
);
  logic [15:0] sync_run, gate_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_run <= '0;
      gate_run <= '0;
    end else begin
      sync_run <= sync_out ? sync_run + 16'd1 : 16'd0;
      gate_run <= gate_out ? gate_run + 16'd1 : 16'd0;
    end
  end

  assert_abort_closes_R8: assert property (@(posedge clk) disable iff (rst)
    cmd_abort |=> !acq_active);

  assert_abort_no_end_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_abort && acq_active) |=> !$rose(sync_out));

  assert_end_with_close_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_out) |-> $fell(acq_active));

  assert_end_width_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(sync_out) |-> (sync_run >= 16'(PULSE_W)));

  assert_gate_with_open_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_out) |-> $rose(acq_active));

  assert_gate_enable_R7: assert property (@(posedge clk) disable iff (rst)
    ($rose(acq_active) && !$past(gate_en)) |-> !$rose(gate_out));

  assert_gate_width_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(gate_out) |-> (gate_run >= 16'(PULSE_W)));

  assert_close_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
    (acq_active && !ms_tick && !cmd_abort) |=> acq_active);
endmodule

bind acq_window_ctrl acqw_checker #(.PULSE_W(PULSE_W)) u_acqw_checker (
  .clk(clk), .rst(rst), .cmd_abort(cmd_abort), .ms_tick(ms_tick),
  .gate_en(gate_en), .acq_active(acq_active), .sync_out(sync_out),
  .gate_out(gate_out)
);

// File: tb/tb_acq_window_ctrl.sv
module tb_acq_window_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_start = 0, cmd_abort = 0, sync_in = 0, ms_tick = 0;
  logic [31:0] dwell_ms = 0;
  logic        ext_trig_en = 0, gate_en = 0;
  logic        acq_active, sync_out, gate_out;

  int total = 0;
  int bad   = 0;
  bit reported = 0;

  always #4 clk = ~clk;

  acq_window_ctrl dut (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_abort(cmd_abort),
    .sync_in(sync_in), .ms_tick(ms_tick), .dwell_ms(dwell_ms),
    .ext_trig_en(ext_trig_en), .gate_en(gate_en),
    .acq_active(acq_active), .sync_out(sync_out), .gate_out(gate_out)
  );

  task automatic cyc(); @(negedge clk); endtask

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
    end
    $finish;
  endtask

  function automatic int exp_ticks(input logic [31:0] dv);
    return (dv == 0) ? 1 : int'(dv);
  endfunction

  // One full measurement with closing by expiry.
  task automatic measure(input logic [31:0] dv, input bit ext, input bit gen,
                         input int gap, input int arm_wait);
    int ticks = 0, phase = 0, gcnt = 0, scnt = 0, guard = 0;
    dwell_ms = dv; ext_trig_en = ext; gate_en = gen;
    cmd_start = 1; cyc(); cmd_start = 0;
    if (ext) begin
      chk("R3 armed, not open", acq_active, 0);
      for (int i = 0; i < arm_wait; i++) begin
        ms_tick = i[0];
        cmd_start = (i % 7 == 3);
        cyc();
      end
      ms_tick = 0; cmd_start = 0;
      chk("R3 still waiting", acq_active, 0);
      sync_in = 1; cyc(); cyc();
      chk("R3 not yet open after 2 edges", acq_active, 0);
      cyc();
      chk("R3 open at third edge", acq_active, 1);
      sync_in = 0;
    end else begin
      chk("R2 open at start edge", acq_active, 1);
    end
    chk("R7 gate at open", gate_out, gen);
    while (acq_active && guard < 5000) begin
      if (gate_out) gcnt++;
      ms_tick = (phase == gap - 1);
      phase = (phase == gap - 1) ? 0 : phase + 1;
      cmd_start = ms_tick ? 1'b0 : 1'($urandom_range(0, 1));
      if (ms_tick) ticks++;
      guard++;
      cyc();
    end
    ms_tick = 0; cmd_start = 0;
    chk("R4 R5 R9 ticks in window", ticks, exp_ticks(dv));
    chk("R6 end pulse at close", sync_out, 1);
    while ((sync_out || gate_out) && guard < 5100) begin
      if (sync_out) scnt++;
      if (gate_out) gcnt++;
      guard++;
      cyc();
    end
    chk("R6 end pulse width", scnt, 4);
    chk("R7 gate count", gcnt, gen ? 4 : 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) cyc();
    chk("R1 active low in reset", acq_active, 0);
    chk("R1 end low in reset", sync_out, 0);
    rst = 0; cyc();
    chk("R1 gate low after reset", gate_out, 0);

    // sync edges while idle, trigger mode off
    for (int i = 0; i < 10; i++) begin sync_in = ~sync_in; cyc(); end
    sync_in = 0; repeat (4) cyc();
    chk("R2 sync ignored in idle", acq_active, 0);
    chk("R2 no end pulse in idle", sync_out, 0);

    measure(32'd3, 0, 1, 1, 0);
    measure(32'd0, 0, 1, 2, 0);    // R5 clamp
    measure(32'd2, 1, 0, 3, 300);  // R3 long wait

    // level already high at arming
    sync_in = 1; ext_trig_en = 1; repeat (5) cyc();
    cmd_start = 1; cyc(); cmd_start = 0;
    repeat (40) cyc();
    chk("R3 held level does not open", acq_active, 0);
    cmd_abort = 1; cyc(); cmd_abort = 0;
    sync_in = 0; repeat (3) cyc(); sync_in = 1; repeat (6) cyc(); sync_in = 0;
    chk("R8 abort from armed", acq_active, 0);

    // abort while running, with a tick in the same cycle
    ext_trig_en = 0; gate_en = 0; dwell_ms = 32'd10;
    cmd_start = 1; cyc(); cmd_start = 0;
    ms_tick = 1; cyc(); ms_tick = 0; cyc();
    cmd_abort = 1; cmd_start = 1; ms_tick = 1; cyc();
    cmd_abort = 0; cmd_start = 0; ms_tick = 0;
    chk("R8 abort from running", acq_active, 0);
    begin
      int seen = 0;
      for (int i = 0; i < 12; i++) begin if (sync_out) seen++; cyc(); end
      chk("R8 no end pulse after abort", seen, 0);
    end

    // dwell at the top of the 32-bit range
    dwell_ms = 32'hFFFF_FFFF;
    cmd_start = 1; cyc(); cmd_start = 0;
    for (int i = 0; i < 200; i++) begin ms_tick = 1; cyc(); end
    ms_tick = 0;
    chk("R4 long dwell still open", acq_active, 1);
    cmd_abort = 1; cyc(); cmd_abort = 0;
    chk("R8 abort long dwell", acq_active, 0);
    repeat (6) cyc();

    for (int it = 0; it < 40; it++) begin
      measure(32'($urandom_range(0, 6)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), int'($urandom_range(1, 5)),
              int'($urandom_range(0, 30)));
    end
    summary();
  end
endmodule